// File: doc/BRIEF.md
# Register-Bank Packet Loader with Interrupt-Free Dispatch

This block places the extracted fields of each packet, and one word of flow state, straight into a bank of a processor's register file, so that the processor never has to issue load instructions for packet input. The register file has two I/O banks of 32 registers. One bank is filled by this block while the processor works on the packet already sitting in the other bank. When the filling bank is complete and the processor reports that it is idle, the two banks change roles.

The processor is started without an interrupt. While it has nothing to do, it spins on a jump through a fixed program register (index 4). At handover the block overwrites that register with the start address of the matching packet handler, so the next jump lands in the handler. The address comes from a 16-entry dispatch table indexed by the packet's 4-bit type code. The table is filled through a simple write port. A new-packet flag tells the processor that work is waiting. The processor pulls its idle line low when it starts a packet and raises it again when it has finished.

Top module: `pkt_reg_loader`

## Requirements
- R1: Field word k of a packet (counting from 0) is written to the bank write port in the same cycle in which it is accepted (`fld_valid` and `fld_ready` both high), with `bank_idx` = k, `bank_wdata` = the word, and `bank_sel` = the current loading bank.
- R2: Once the field word that carries `fld_last` has been accepted, `fld_ready` stays low. The one flow-state word is then accepted on the state port and written to index 31 of the same bank.
- R3: After reset the loading bank is 0. `proc_bank` is always the other bank. Every handover swaps the two.
- R4: A handover happens only when the loading bank holds a complete packet, `cpu_idle` is high, and no earlier packet is still waiting to be started. In the cycle after the handover edge, `wake_we` is high for exactly one cycle with `wake_idx` = 4, `pkt_new` is high, and the banks have swapped.
- R5: `pkt_new` stays high until `cpu_idle` falls. It is low from the cycle after the falling edge onwards.
- R6: While a complete packet waits for handover, `fld_ready` and `st_ready` are low, and input held valid produces no bank write.
- R7: `wake_wdata` is the dispatch table entry at the 4-bit type code that `fld_type` carried on the packet's first field word. A table write through `tbl_we`/`tbl_addr`/`tbl_data` changes the address used by later handovers.
- R8: Packets of 10, 20 and 30 field words are loaded correctly. At most 31 field words fit, because slot 31 holds the state word.
- R9: In reset, `pkt_new`, `wake_we`, `bank_we` and `st_ready` are low and `fld_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fld_valid | input | 1 | Field word valid |
| fld_ready | output | 1 | Loader accepts a field word |
| fld_data | input | 32 | Field word |
| fld_last | input | 1 | Last field word of the packet |
| fld_type | input | 4 | Packet type code, taken from the first word |
| st_valid | input | 1 | Flow-state word valid |
| st_ready | output | 1 | Loader accepts the state word |
| st_data | input | 32 | Flow-state word |
| bank_we | output | 1 | I/O bank register write enable |
| bank_sel | output | 1 | Bank being written |
| bank_idx | output | 5 | Register index within the bank |
| bank_wdata | output | 32 | Register write data |
| proc_bank | output | 1 | Bank the processor works on |
| wake_we | output | 1 | Write strobe to the spin-loop jump register |
| wake_idx | output | 5 | Index of that register (always 4) |
| wake_wdata | output | 32 | Handler start address |
| pkt_new | output | 1 | A loaded packet waits for the processor |
| cpu_idle | input | 1 | Processor idle line |
| tbl_we | input | 1 | Dispatch table write enable |
| tbl_addr | input | 4 | Dispatch table entry |
| tbl_data | input | 32 | Handler address to store |

## Verification
The assertions check these rules on every cycle:
- The wake strobe is a single-cycle pulse.
- A wake follows only a cycle with `cpu_idle` high, and it always swaps the banks.
- `pkt_new` cannot drop while the processor stays idle.
- A rising `pkt_new` comes together with a wake.
- The field port closes after the last word, and no field word lands beyond slot 30.

Only the bench scenarios can show that the data reaches the right bank index, and that the handler address follows the type code and a later table rewrite. They also show that a finished packet is held back while the previous one has not been started or is still being processed. Finally, the bench runs packets of three sizes with gaps in the input.

// File: rtl/pktld_pkg.sv
package pktld_pkg;
    localparam int WORD_W      = 32;
    localparam int TYPE_W      = 4;
    localparam int BANK_REGS   = 32;
    localparam int WAKE_REG    = 4;

    typedef enum logic [1:0] {
        FILL_FIELDS,
        FILL_STATE,
        FILL_HELD
    } fill_state_e;

    function automatic logic other_bank(input logic b);
        return ~b;
    endfunction
endpackage

// File: rtl/ldr_dispatch_tbl.sv
module ldr_dispatch_tbl #(
    parameter int WORD_W = pktld_pkg::WORD_W,
    parameter int TYPE_W = pktld_pkg::TYPE_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [TYPE_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [TYPE_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int ENTRIES = 1 << TYPE_W;

    logic [WORD_W-1:0] entry [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) entry[wr_addr] <= wr_data;
    end

    assign rd_data = entry[rd_addr];
endmodule

// File: rtl/ldr_fill_ctl.sv
module ldr_fill_ctl
    import pktld_pkg::*;
#(
    parameter int WORD_W     = pktld_pkg::WORD_W,
    parameter int TYPE_W     = pktld_pkg::TYPE_W,
    parameter int IDX_W      = $clog2(pktld_pkg::BANK_REGS),
    parameter int STATE_SLOT = pktld_pkg::BANK_REGS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fld_valid,
    output logic              fld_ready,
    input  logic [WORD_W-1:0] fld_data,
    input  logic              fld_last,
    input  logic [TYPE_W-1:0] fld_type,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [WORD_W-1:0] st_data,
    input  logic              grant,
    output logic              full,
    output logic [TYPE_W-1:0] pkt_type,
    output logic              bank_we,
    output logic [IDX_W-1:0]  bank_idx,
    output logic [WORD_W-1:0] bank_wdata
);
    fill_state_e       state;
    logic [IDX_W-1:0]  idx;
    logic [TYPE_W-1:0] type_q;
    logic              fld_fire, st_fire;

    assign fld_ready  = (state == FILL_FIELDS);
    assign st_ready   = (state == FILL_STATE);
    assign full       = (state == FILL_HELD);
    assign fld_fire   = fld_valid && fld_ready;
    assign st_fire    = st_valid && st_ready;
    assign bank_we    = fld_fire || st_fire;
    assign bank_idx   = st_fire ? IDX_W'(STATE_SLOT) : idx;
    assign bank_wdata = st_fire ? st_data : fld_data;
    assign pkt_type   = type_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FILL_FIELDS;
            idx    <= '0;
            type_q <= '0;
        end else begin
            case (state)
                FILL_FIELDS: if (fld_fire) begin
                    if (idx == '0) type_q <= fld_type;
                    if (fld_last) begin
                        state <= FILL_STATE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                FILL_STATE: if (st_fire) state <= FILL_HELD;
                FILL_HELD:  if (grant) state <= FILL_FIELDS;
                default:    state <= FILL_FIELDS;
            endcase
        end
    end

    // R2: the field port closes after the last word
    assert_port_closes_R2: assert property (@(posedge clk) disable iff (rst)
        (fld_fire && fld_last) |=> !fld_ready);
    // R8: field words stay below the state slot
    assert_slot_bound_R8: assert property (@(posedge clk) disable iff (rst)
        fld_fire |-> (idx < IDX_W'(STATE_SLOT)));
endmodule

// File: rtl/ldr_wake_ctl.sv
module ldr_wake_ctl
    import pktld_pkg::*;
#(
    parameter int WORD_W   = pktld_pkg::WORD_W,
    parameter int IDX_W    = $clog2(pktld_pkg::BANK_REGS),
    parameter int WAKE_REG = pktld_pkg::WAKE_REG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              full,
    input  logic              cpu_idle,
    input  logic [WORD_W-1:0] handler,
    output logic              grant,
    output logic              pkt_new,
    output logic              ld_bank,
    output logic              wake_we,
    output logic [IDX_W-1:0]  wake_idx,
    output logic [WORD_W-1:0] wake_wdata
);
    logic pend, idle_q;

    assign grant    = full && cpu_idle && !pend;
    assign pkt_new  = pend;
    assign wake_idx = IDX_W'(WAKE_REG);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= 1'b0;
            idle_q     <= 1'b1;
            ld_bank    <= 1'b0;
            wake_we    <= 1'b0;
            wake_wdata <= '0;
        end else begin
            idle_q  <= cpu_idle;
            wake_we <= grant;
            if (grant) begin
                ld_bank    <= other_bank(ld_bank);
                wake_wdata <= handler;
                pend       <= 1'b1;
            end else if (idle_q && !cpu_idle) begin
                pend <= 1'b0;
            end
        end
    end

    // R4: wake is a single pulse
    assert_wake_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        wake_we |=> !wake_we);
    // R4: a wake needs the processor idle on the handover edge
    assert_wake_needs_idle_R4: assert property (@(posedge clk) disable iff (rst)
        wake_we |-> $past(cpu_idle));
    // R3: every wake swaps the banks
    assert_bank_flip_R3: assert property (@(posedge clk) disable iff (rst)
        wake_we |-> (ld_bank != $past(ld_bank)));
    // R5: the flag holds while the processor stays idle
    assert_new_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (pkt_new && cpu_idle) |=> pkt_new);
endmodule

// File: rtl/pkt_reg_loader.sv
module pkt_reg_loader
    import pktld_pkg::*;
#(
    parameter int WORD_W    = pktld_pkg::WORD_W,
    parameter int TYPE_W    = pktld_pkg::TYPE_W,
    parameter int BANK_REGS = pktld_pkg::BANK_REGS,
    parameter int WAKE_REG  = pktld_pkg::WAKE_REG
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         fld_valid,
    output logic                         fld_ready,
    input  logic [WORD_W-1:0]            fld_data,
    input  logic                         fld_last,
    input  logic [TYPE_W-1:0]            fld_type,
    input  logic                         st_valid,
    output logic                         st_ready,
    input  logic [WORD_W-1:0]            st_data,
    output logic                         bank_we,
    output logic                         bank_sel,
    output logic [$clog2(BANK_REGS)-1:0] bank_idx,
    output logic [WORD_W-1:0]            bank_wdata,
    output logic                         proc_bank,
    output logic                         wake_we,
    output logic [$clog2(BANK_REGS)-1:0] wake_idx,
    output logic [WORD_W-1:0]            wake_wdata,
    output logic                         pkt_new,
    input  logic                         cpu_idle,
    input  logic                         tbl_we,
    input  logic [TYPE_W-1:0]            tbl_addr,
    input  logic [WORD_W-1:0]            tbl_data
);
    localparam int IDX_W      = $clog2(BANK_REGS);
    localparam int STATE_SLOT = BANK_REGS - 1;

    logic              grant, full, ld_bank;
    logic [TYPE_W-1:0] pkt_type;
    logic [WORD_W-1:0] handler;

    ldr_fill_ctl #(.WORD_W(WORD_W), .TYPE_W(TYPE_W), .IDX_W(IDX_W),
                   .STATE_SLOT(STATE_SLOT)) u_fill (
        .clk(clk), .rst(rst),
        .fld_valid(fld_valid), .fld_ready(fld_ready), .fld_data(fld_data),
        .fld_last(fld_last), .fld_type(fld_type),
        .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
        .grant(grant), .full(full), .pkt_type(pkt_type),
        .bank_we(bank_we), .bank_idx(bank_idx), .bank_wdata(bank_wdata)
    );

    ldr_dispatch_tbl #(.WORD_W(WORD_W), .TYPE_W(TYPE_W)) u_tbl (
        .clk(clk), .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_data),
        .rd_addr(pkt_type), .rd_data(handler)
    );

    ldr_wake_ctl #(.WORD_W(WORD_W), .IDX_W(IDX_W), .WAKE_REG(WAKE_REG)) u_wake (
        .clk(clk), .rst(rst), .full(full), .cpu_idle(cpu_idle),
        .handler(handler), .grant(grant), .pkt_new(pkt_new),
        .ld_bank(ld_bank), .wake_we(wake_we), .wake_idx(wake_idx),
        .wake_wdata(wake_wdata)
    );

    assign bank_sel  = ld_bank;
    assign proc_bank = other_bank(ld_bank);

    // R4: a new packet flag only rises together with a wake
    assert_new_with_wake_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pkt_new) |-> wake_we);
    // R6: a waiting packet blocks both input ports
    assert_hold_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (pkt_new && full) |-> (!fld_ready && !st_ready));
endmodule

// File: tb/sim_pkt_reg_loader.sv
module sim_pkt_reg_loader;
    logic        clk = 0, rst = 1;
    logic        fld_valid = 0, fld_last = 0, st_valid = 0, cpu_idle = 1;
    logic [31:0] fld_data = 0, st_data = 0, tbl_data = 0;
    logic [3:0]  fld_type = 0, tbl_addr = 0;
    logic        tbl_we = 0;
    logic        fld_ready, st_ready, bank_we, bank_sel, proc_bank, wake_we, pkt_new;
    logic [4:0]  bank_idx, wake_idx;
    logic [31:0] bank_wdata, wake_wdata;

    int tests = 0, fails = 0;
    logic exp_ld = 0;
    logic [37:0] wr_q[$];
    logic [31:0] wk_q[$];
    logic [31:0] tbl_model [16];

    always #5 clk = ~clk;

    pkt_reg_loader u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic settle; @(negedge clk); #1; endtask

    // monitor: pops expected writes as the design produces them
    initial forever begin
        @(negedge clk); #4;
        if (!rst && bank_we) begin
            if (wr_q.size() == 0) chk(0, "R6", "unexpected bank write", {bank_sel, bank_idx, bank_wdata}, 0);
            else begin
                logic [37:0] e;
                e = wr_q.pop_front();
                chk({bank_sel, bank_idx, bank_wdata} == e, (e[36:32] == 5'd31) ? "R2" : "R1",
                    "bank write", {bank_sel, bank_idx, bank_wdata}, e);
            end
        end
        if (!rst && wake_we) begin
            if (wk_q.size() == 0) chk(0, "R4", "unexpected wake", wake_wdata, 0);
            else begin
                logic [31:0] e;
                e = wk_q.pop_front();
                chk(wake_wdata == e, "R7", "handler address", wake_wdata, e);
                chk(wake_idx == 5'd4, "R4", "wake index", wake_idx, 4);
            end
        end
    end

    task automatic tbl_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); tbl_we = 1; tbl_addr = a; tbl_data = d; tbl_model[a] = d;
        @(negedge clk); tbl_we = 0;
    endtask

    task automatic send_fields(input int n, input logic [3:0] typ, input logic [31:0] base, input bit gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            fld_valid = 1; fld_data = base + k; fld_last = (k == n - 1); fld_type = typ;
            while (!fld_ready) @(negedge clk);
            wr_q.push_back({exp_ld, 5'(k), base + 32'(k)});
            if (gap) begin @(negedge clk); fld_valid = 0; end
        end
        @(negedge clk); fld_valid = 0; fld_last = 0;
    endtask

    task automatic send_state(input logic [31:0] d);
        @(negedge clk); st_valid = 1; st_data = d;
        while (!st_ready) @(negedge clk);
        wr_q.push_back({exp_ld, 5'd31, d});
        @(negedge clk); st_valid = 0;
    endtask

    task automatic finish_run;
        chk(wr_q.size() == 0, "R1", "pending bank writes", wr_q.size(), 0);
        chk(wk_q.size() == 0, "R4", "pending wakes", wk_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R9 reset values
        chk(pkt_new == 0 && wake_we == 0 && bank_we == 0, "R9", "reset strobes", {pkt_new, wake_we, bank_we}, 0);
        chk(fld_ready == 1 && st_ready == 0, "R9", "reset ready", {fld_ready, st_ready}, 2'b10);
        chk(proc_bank == 1, "R3", "reset proc bank", proc_bank, 1);
        @(negedge clk); rst = 0;
        for (int t = 0; t < 16; t++) tbl_write(4'(t), 32'h0040_0000 + 32'(t) * 32'h40);

        // Packet A: 10 words, type 3, into bank 0, handed over at once (R8)
        wk_q.push_back(tbl_model[3]);
        send_fields(10, 4'd3, 32'hA000_0000, 0);
        chk(fld_ready == 0, "R2", "field port closed after last", fld_ready, 0);
        send_state(32'h5A5A_0001);
        settle();
        chk(pkt_new == 1, "R4", "pkt_new after handover", pkt_new, 1);
        chk(proc_bank == 0, "R3", "proc bank after first swap", proc_bank, 0);
        exp_ld = 1;

        // Packet B: 20 words with gaps, type 7, into bank 1 while A is pending
        send_fields(20, 4'd7, 32'hB000_0000, 1);
        send_state(32'h5A5A_0002);
        @(negedge clk); fld_valid = 1; fld_data = 32'hDEAD_BEEF; st_valid = 1;
        for (int i = 0; i < 4; i++) begin
            settle();
            chk(fld_ready == 0 && st_ready == 0, "R6", "ports closed while held", {fld_ready, st_ready}, 0);
            chk(bank_we == 0, "R6", "no write while held", bank_we, 0);
            chk(pkt_new == 1, "R5", "flag holds while idle", pkt_new, 1);
        end
        @(negedge clk); fld_valid = 0; st_valid = 0; cpu_idle = 0;
        settle();
        chk(pkt_new == 0, "R5", "flag clears after idle falls", pkt_new, 0);
        repeat (4) begin
            settle();
            chk(proc_bank == 0, "R4", "no swap while processor busy", proc_bank, 0);
        end
        wk_q.push_back(tbl_model[7]);
        @(negedge clk); cpu_idle = 1;
        settle();
        chk(pkt_new == 1 && proc_bank == 1, "R4", "handover B", {pkt_new, proc_bank}, 2'b11);
        exp_ld = 0;

        // Packet C: 30 words, type 15 after a table rewrite (R7)
        tbl_write(4'd15, 32'hCAFE_0F00);
        send_fields(30, 4'd15, 32'hC000_0000, 0);
        send_state(32'h5A5A_0003);
        @(negedge clk); cpu_idle = 0;
        @(negedge clk); cpu_idle = 1;
        wk_q.push_back(32'hCAFE_0F00);
        settle();
        chk(pkt_new == 1 && proc_bank == 0, "R4", "handover C", {pkt_new, proc_bank}, 2'b10);
        exp_ld = 1;

        // Packet D: processor finishes C before D completes, type 0
        @(negedge clk); cpu_idle = 0;
        @(negedge clk); cpu_idle = 1;
        settle();
        chk(pkt_new == 0, "R5", "flag cleared before D", pkt_new, 0);
        wk_q.push_back(tbl_model[0]);
        send_fields(10, 4'd0, 32'hD000_0000, 1);
        send_state(32'h5A5A_0004);
        settle();
        chk(pkt_new == 1 && proc_bank == 1, "R4", "handover D", {pkt_new, proc_bank}, 2'b11);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule